// File: doc/BRIEF.md
# Framebuffer descriptor DMA fetcher

This block feeds a display pipeline with pixel words read from memory, one framebuffer per frame. Each frame is described by a four-word descriptor in memory. The descriptor holds a link to the next descriptor, the start address of the buffer, a frame identifier and a command word. The command word carries the transfer length and the interrupt requests for that frame. After a start pulse, the engine takes the first descriptor address from its input and reads that descriptor. It then fetches the buffer in bursts into an internal pixel FIFO. Once the last word of the buffer is in the FIFO, it follows the link to the next descriptor. A descriptor that links to itself makes the same buffer refresh every frame.

Memory is reached through a simple read port. A request carries a byte address and a word count, and it is accepted when grant is high. The words of each accepted request come back in order, one per cycle in which the valid signal is high, and only one request is ever outstanding. The display side pops words through a valid/ready handshake. The descriptor now being streamed is shown on three read-only outputs, and the block raises one-cycle pulses at start of frame, at end of frame, and when the FIFO underflows.

Top module: `dfetch_top`

## Requirements
- R1: After a start pulse in the idle state, the engine issues a 4-word read at start_addr. The returned words are taken in this order: link to next descriptor, buffer byte address, frame identifier, command.
- R2: The frame length in 32-bit words is command bits 23:0. The words from the buffer address upward are delivered to the pixel output in address order, with nothing missing and nothing duplicated.
- R3: The largest data burst is set by burst_sel: 0 gives 4 words, 1 gives 8, 2 gives 16, and 3 also gives 16.
- R4: Each data burst starts where the previous one ended, 4 bytes per word. When fewer words remain than the burst size, the last burst is shortened to the remaining count, so no word past the buffer is ever requested.
- R5: Once the last word of a frame has entered the FIFO, the next descriptor is read from the link address. A descriptor that links to its own address repeats its buffer every frame.
- R6: cur_buf, cur_id and cur_cmd read zero after reset. They take the buffer address, identifier and command of a descriptor in the cycle after its command word arrives.
- R7: sof_irq pulses for one cycle after a descriptor whose command bit 31 is set has been read. eof_irq pulses for one cycle after the last word of a frame whose command bit 30 is set has entered the FIFO. With these bits clear, no pulse is raised.
- R8: A descriptor with a length of zero issues no data read. It counts as an ended frame at once, pulsing eof_irq if bit 30 is set, and the engine moves to its link.
- R9: A data read is issued only when the FIFO has at least as many free entries as the burst needs. A consumer that stops popping therefore stalls the reads, and the FIFO never overflows.
- R10: ufl_irq pulses in the cycle after one in which ufl_en was high, the engine was not idle, pix_ready was high and the FIFO was empty. It stays low while the engine is idle or while ufl_en is low.
- R11: After reset the block is idle: rd_req, pix_valid and all interrupt outputs are low.
- R12: A start pulse while the engine is active has no effect on the read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking the chain at start_addr (idle only) |
| start_addr | input | 32 | Byte address of the first descriptor |
| burst_sel | input | 2 | Largest burst size selector |
| ufl_en | input | 1 | Enables the underflow pulse |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Byte address of the request |
| rd_len | output | 5 | Word count of the request |
| rd_gnt | input | 1 | Request accepted |
| rd_rvalid | input | 1 | Read data word valid |
| rd_rdata | input | 32 | Read data word |
| pix_valid | output | 1 | FIFO holds a word |
| pix_data | output | 32 | Head word of the FIFO |
| pix_ready | input | 1 | Consumer pops the head word |
| cur_buf | output | 32 | Buffer address of the current descriptor |
| cur_id | output | 32 | Identifier of the current descriptor |
| cur_cmd | output | 32 | Command word of the current descriptor |
| sof_irq | output | 1 | Start-of-frame pulse |
| eof_irq | output | 1 | End-of-frame pulse |
| ufl_irq | output | 1 | FIFO underflow pulse |

## Verification
The bench builds the block with its default parameters: a 32-entry FIFO, a largest burst of 16 words and a 24-bit length field. With these values, a sweep over all four burst selections and every frame length from 1 to 20 words covers a frame that ends exactly on a burst boundary, a frame that needs a short final burst, and a frame shorter than any burst. The FIFO is small enough that a two-descriptor chain with no consumer fills it to an exact, predictable stall point. The bench checks the stall word count, the shadow values and the interrupt counts at that point, then drains the FIFO and checks the data order across descriptor changes.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
   localparam int WORD_W      = 32;
   localparam int DESC_WORDS  = 4;
   localparam int CMD_SOF_BIT = 31;
   localparam int CMD_EOF_BIT = 30;
   localparam int CMD_PAL_BIT = 28;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DREQ,
      ST_DRSP,
      ST_BREQ,
      ST_BRSP
   } fetch_st_e;
endpackage

// File: rtl/dfetch_fifo.sv
module dfetch_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] free
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   if (DEPTH < 2) begin : g_bad_depth
      $error("dfetch_fifo: DEPTH must be at least 2");
   end

   if (POW2) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign free    = CW'(DEPTH) - cnt;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/dfetch_burst_sizer.sv
module dfetch_burst_sizer #(
   parameter int LEN_W     = 24,
   parameter int MAX_BURST = 16,
   localparam int BL_W     = $clog2(MAX_BURST + 1)
) (
   input  logic [1:0]       sel,
   input  logic [LEN_W-1:0] remain,
   output logic [BL_W-1:0]  blen
);
   logic [BL_W-1:0] cand [4];
   logic [BL_W-1:0] lim;

   if (LEN_W <= BL_W) begin : g_bad_len
      $error("dfetch_burst_sizer: LEN_W must exceed the burst count width");
   end

   for (genvar g = 0; g < 4; g++) begin : g_cand
      localparam int RAW = (g == 3) ? 16 : (4 << g);
      localparam int CAP = (RAW > MAX_BURST) ? MAX_BURST : RAW;
      assign cand[g] = BL_W'(CAP);
   end

   always_comb begin
      lim = cand[sel];
      if (remain < LEN_W'(lim)) blen = BL_W'(remain);
      else                      blen = lim;
   end
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top
   import dfetch_pkg::*;
#(
   parameter int LEN_W      = 24,
   parameter int FIFO_DEPTH = 32,
   parameter int MAX_BURST  = 16,
   localparam int BL_W      = $clog2(MAX_BURST + 1),
   localparam int FC_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       start_addr,
   input  logic [1:0]        burst_sel,
   input  logic              ufl_en,
   output logic              rd_req,
   output logic [31:0]       rd_addr,
   output logic [BL_W-1:0]   rd_len,
   input  logic              rd_gnt,
   input  logic              rd_rvalid,
   input  logic [31:0]       rd_rdata,
   output logic              pix_valid,
   output logic [31:0]       pix_data,
   input  logic              pix_ready,
   output logic [31:0]       cur_buf,
   output logic [31:0]       cur_id,
   output logic [31:0]       cur_cmd,
   output logic              sof_irq,
   output logic              eof_irq,
   output logic              ufl_irq
);
   if (FIFO_DEPTH < MAX_BURST) begin : g_bad_fifo
      $error("dfetch_top: FIFO_DEPTH must hold a full burst");
   end
   if (MAX_BURST < DESC_WORDS) begin : g_bad_burst
      $error("dfetch_top: MAX_BURST must cover a descriptor read");
   end
   if (LEN_W > CMD_PAL_BIT) begin : g_bad_lenw
      $error("dfetch_top: length field overlaps command flags");
   end

   fetch_st_e        st;
   logic [31:0]      dptr, nxt_q, buf_q, id_q, baddr;
   logic [31:0]      cur_buf_q, cur_id_q, cur_cmd_q;
   logic [LEN_W-1:0] remain;
   logic [BL_W-1:0]  bleft, blen;
   logic [1:0]       wcnt;
   logic             sof_q, eof_q, ufl_q;

   logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
   logic [FC_W-1:0]  fifo_free;
   logic             data_ok;
   logic [LEN_W-1:0] new_len;

   dfetch_burst_sizer #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST)) u_sizer (
      .sel    (burst_sel),
      .remain (remain),
      .blen   (blen)
   );

   dfetch_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .wdata (rd_rdata),
      .pop   (fifo_pop),
      .rdata (pix_data),
      .empty (fifo_empty),
      .full  (fifo_full),
      .free  (fifo_free)
   );

   assign new_len   = rd_rdata[LEN_W-1:0];
   assign data_ok   = (FC_W'(blen) <= fifo_free) || (FC_W > BL_W && fifo_free >= FC_W'(blen));
   assign rd_req    = (st == ST_DREQ) || ((st == ST_BREQ) && (FC_W'(blen) <= fifo_free));
   assign rd_addr   = (st == ST_DREQ) ? dptr : baddr;
   assign rd_len    = (st == ST_DREQ) ? BL_W'(DESC_WORDS) : blen;
   assign fifo_push = (st == ST_BRSP) && rd_rvalid;
   assign fifo_pop  = pix_ready && !fifo_empty;
   assign pix_valid = !fifo_empty;

   assign cur_buf = cur_buf_q;
   assign cur_id  = cur_id_q;
   assign cur_cmd = cur_cmd_q;
   assign sof_irq = sof_q;
   assign eof_irq = eof_q;
   assign ufl_irq = ufl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         dptr      <= '0;
         nxt_q     <= '0;
         buf_q     <= '0;
         id_q      <= '0;
         baddr     <= '0;
         cur_buf_q <= '0;
         cur_id_q  <= '0;
         cur_cmd_q <= '0;
         remain    <= '0;
         bleft     <= '0;
         wcnt      <= '0;
         sof_q     <= 1'b0;
         eof_q     <= 1'b0;
         ufl_q     <= 1'b0;
      end else begin
         sof_q <= 1'b0;
         eof_q <= 1'b0;
         ufl_q <= ufl_en && (st != ST_IDLE) && pix_ready && fifo_empty;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  dptr <= start_addr;
                  st   <= ST_DREQ;
               end
            end
            ST_DREQ: begin
               if (rd_gnt) begin
                  wcnt <= '0;
                  st   <= ST_DRSP;
               end
            end
            ST_DRSP: begin
               if (rd_rvalid) begin
                  wcnt <= wcnt + 1'b1;
                  case (wcnt)
                     2'd0: nxt_q <= rd_rdata;
                     2'd1: buf_q <= rd_rdata;
                     2'd2: id_q  <= rd_rdata;
                     default: begin
                        cur_buf_q <= buf_q;
                        cur_id_q  <= id_q;
                        cur_cmd_q <= rd_rdata;
                        baddr     <= buf_q;
                        remain    <= new_len;
                        sof_q     <= rd_rdata[CMD_SOF_BIT];
                        if (new_len == '0) begin
                           eof_q <= rd_rdata[CMD_EOF_BIT];
                           dptr  <= nxt_q;
                           st    <= ST_DREQ;
                        end else begin
                           st <= ST_BREQ;
                        end
                     end
                  endcase
               end
            end
            ST_BREQ: begin
               if (rd_req && rd_gnt && data_ok) begin
                  bleft  <= blen;
                  baddr  <= baddr + (32'(blen) << 2);
                  remain <= remain - LEN_W'(blen);
                  st     <= ST_BRSP;
               end
            end
            ST_BRSP: begin
               if (rd_rvalid) begin
                  bleft <= bleft - 1'b1;
                  if (bleft == BL_W'(1)) begin
                     if (remain == '0) begin
                        eof_q <= cur_cmd_q[CMD_EOF_BIT];
                        dptr  <= nxt_q;
                        st    <= ST_DREQ;
                     end else begin
                        st <= ST_BREQ;
                     end
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dfetch_chk.sv
module dfetch_chk #(
   parameter int MAX_BURST = 16,
   localparam int BL_W     = $clog2(MAX_BURST + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_req,
   input logic            rd_gnt,
   input logic [31:0]     rd_addr,
   input logic [BL_W-1:0] rd_len,
   input logic            fifo_push,
   input logic            fifo_full,
   input logic            pix_valid,
   input logic            pix_ready,
   input logic            ufl_en,
   input logic            sof_irq,
   input logic            eof_irq,
   input logic            ufl_irq
);
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !fifo_full);

   a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_len != '0) && (rd_len <= BL_W'(MAX_BURST)));

   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_gnt) |=> rd_req && $stable(rd_addr) && $stable(rd_len));

   a_r7_sof_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sof_irq |=> !sof_irq);

   a_r7_eof_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eof_irq |=> !eof_irq);

   a_r10_ufl_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ufl_irq |-> $past(ufl_en));

   a_r10_ufl_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ufl_irq |-> $past(pix_ready && !pix_valid));
endmodule

bind dfetch_top dfetch_chk #(.MAX_BURST(MAX_BURST)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_gnt    (rd_gnt),
   .rd_addr   (rd_addr),
   .rd_len    (rd_len),
   .fifo_push (fifo_push),
   .fifo_full (fifo_full),
   .pix_valid (pix_valid),
   .pix_ready (pix_ready),
   .ufl_en    (ufl_en),
   .sof_irq   (sof_irq),
   .eof_irq   (eof_irq),
   .ufl_irq   (ufl_irq)
);

// File: tb/dfetch_top_test.sv
`timescale 1ns/1ps
module dfetch_top_test;
   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n, start, ufl_en, rd_gnt, rd_rvalid, pix_ready;
   logic [31:0] start_addr, rd_rdata;
   logic [1:0]  burst_sel;
   logic        rd_req, pix_valid, sof_irq, eof_irq, ufl_irq;
   logic [31:0] rd_addr, pix_data, cur_buf, cur_id, cur_cmd;
   logic [4:0]  rd_len;

   always #4 clk = ~clk;

   dfetch_top #(.FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .burst_sel(burst_sel), .ufl_en(ufl_en), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_len(rd_len), .rd_gnt(rd_gnt), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
      .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
      .cur_buf(cur_buf), .cur_id(cur_id), .cur_cmd(cur_cmd),
      .sof_irq(sof_irq), .eof_irq(eof_irq), .ufl_irq(ufl_irq)
   );

   int n_tests = 0, n_fail = 0;
   logic [31:0] desc_w [0:15];
   logic [31:0] req_a [0:255];
   int          req_l [0:255];
   int          nreq;
   logic [31:0] exp_a [0:255];
   int          exp_l [0:255];
   int          nexp;
   logic [31:0] got [0:1023];
   int          ngot, nsof, neof, nufl, rdy_mode;

   function automatic logic [31:0] pat(logic [31:0] a);
      return (a * 32'd2654435761) ^ 32'h3C5A0000;
   endfunction

   function automatic logic [31:0] mem_rd(logic [31:0] a);
      if (a >= 32'h100 && a < 32'h140) return desc_w[(a - 32'h100) >> 2];
      return pat(a);
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // memory model: grant always, latency one cycle, in-order words
   initial begin
      rd_gnt = 1'b1; rd_rvalid = 1'b0; rd_rdata = '0; nreq = 0;
      forever begin
         @(posedge clk);
         if (rst_n && rd_req) begin
            automatic logic [31:0] a = rd_addr;
            automatic int n = int'(rd_len);
            if (nreq < 256) begin req_a[nreq] = a; req_l[nreq] = n; end
            nreq++;
            @(posedge clk);
            for (int k = 0; k < n; k++) begin
               rd_rvalid <= 1'b1;
               rd_rdata  <= mem_rd(a + 32'(4 * k));
               @(posedge clk);
            end
            rd_rvalid <= 1'b0;
         end
      end
   end

   // consumer and pulse counters, away from the active edge
   initial begin
      pix_ready = 1'b0; ngot = 0; nsof = 0; neof = 0; nufl = 0; rdy_mode = 0;
      forever begin
         @(negedge clk);
         case (rdy_mode)
            0:       pix_ready = 1'b0;
            1:       pix_ready = 1'b1;
            default: pix_ready = ~pix_ready;
         endcase
         if (pix_ready && pix_valid && ngot < 1024) begin
            got[ngot] = pix_data;
            ngot++;
         end
         if (sof_irq) nsof++;
         if (eof_irq) neof++;
         if (ufl_irq) nufl++;
      end
   end

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; start = 1'b0; rdy_mode = 0;
      repeat (30) @(negedge clk);
      nreq = 0; ngot = 0; nsof = 0; neof = 0; nufl = 0; nexp = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic kick(logic [31:0] a);
      @(negedge clk);
      start = 1'b1; start_addr = a;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_words(int n);
      int t = 0;
      while (ngot < n && t < 5000) begin @(negedge clk); t++; end
   endtask

   task automatic set_desc(int slot, logic [31:0] nx, logic [31:0] bf,
                           logic [31:0] id, logic [31:0] cmd);
      desc_w[slot*4]   = nx;
      desc_w[slot*4+1] = bf;
      desc_w[slot*4+2] = id;
      desc_w[slot*4+3] = cmd;
   endtask

   task automatic add_exp(logic [31:0] a, int l);
      exp_a[nexp] = a; exp_l[nexp] = l; nexp++;
   endtask

   task automatic add_frame(logic [31:0] d, logic [31:0] bf, int len, int bs);
      int off = 0;
      add_exp(d, 4);
      while (off < len) begin
         automatic int c = (len - off < bs) ? len - off : bs;
         add_exp(bf + 32'(4 * off), c);
         off += c;
      end
   endtask

   task automatic cmp_reqs(string req);
      int bad = 0;
      int first = -1;
      for (int i = 0; i < nexp; i++)
         if (i >= nreq || req_a[i] != exp_a[i] || req_l[i] != exp_l[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      if (first < 0) check(1'b1, req, "request sequence", 0, 0);
      else check(1'b0, req, "request sequence at index", longint'(req_a[first]),
                 longint'(exp_a[first]));
   endtask

   initial begin
      int blist [4] = '{4, 8, 16, 16};
      rst_n = 1'b0; start = 1'b0; start_addr = '0; burst_sel = '0; ufl_en = 1'b0;
      for (int i = 0; i < 16; i++) desc_w[i] = '0;

      // R11 / R6: reset state
      do_reset();
      check(!rd_req && !pix_valid, "R11", "req/valid after reset", {rd_req, pix_valid}, 0);
      check(!sof_irq && !eof_irq && !ufl_irq, "R11", "irqs after reset",
            {sof_irq, eof_irq, ufl_irq}, 0);
      check(cur_buf == 0 && cur_id == 0 && cur_cmd == 0, "R6", "shadows after reset",
            cur_id, 0);

      // R3 R4 R2 R5: sweep burst selection and frame length, self-linked descriptor
      for (int bs = 0; bs < 4; bs++) begin
         for (int len = 1; len <= 20; len++) begin
            int bad = 0;
            do_reset();
            burst_sel = 2'(bs);
            set_desc(0, 32'h100, 32'h1000, 32'(len), 32'h4000_0000 | 32'(len));
            rdy_mode = (len % 3 == 0) ? 2 : 1;
            kick(32'h100);
            wait_words(2 * len);
            for (int i = 0; i < 2 * len; i++)
               if (got[i] != pat(32'h1000 + 32'(4 * (i % len)))) bad++;
            check(bad == 0 && ngot >= 2 * len, "R2", "mismatched words in two frames", bad, 0);
            add_frame(32'h100, 32'h1000, len, blist[bs]);
            add_frame(32'h100, 32'h1000, len, blist[bs]);
            cmp_reqs((len % blist[bs] != 0) ? "R4" : "R3");
         end
      end

      // R1 R5 R6 R7 R9 R12: two-descriptor chain with consumer stalled
      do_reset();
      burst_sel = 2'd0;
      set_desc(0, 32'h110, 32'h1000, 32'h11, 32'hC000_000A);
      set_desc(1, 32'h100, 32'h2000, 32'h22, 32'h1000_0005);
      kick(32'h100);
      repeat (300) @(negedge clk);
      check(req_a[0] == 32'h100 && req_l[0] == 4, "R1", "first descriptor read",
            req_a[0], 32'h100);
      check(nreq == 15, "R9", "requests before stall", nreq, 15);
      check(!rd_req, "R9", "rd_req while FIFO lacks space", rd_req, 0);
      check(cur_buf == 32'h1000 && cur_id == 32'h11, "R6", "shadow buf/id", cur_id, 32'h11);
      check(cur_cmd == 32'hC000_000A, "R6", "shadow cmd", cur_cmd, 32'hC000_000A);
      check(nsof == 3, "R7", "sof pulses", nsof, 3);
      check(neof == 2, "R7", "eof pulses", neof, 2);
      kick(32'h110);
      repeat (20) @(negedge clk);
      check(nreq == 15, "R12", "requests after start while active", nreq, 15);
      add_frame(32'h100, 32'h1000, 10, 4);
      add_frame(32'h110, 32'h2000, 5, 4);
      add_frame(32'h100, 32'h1000, 10, 4);
      add_frame(32'h110, 32'h2000, 5, 4);
      add_exp(32'h100, 4);
      cmp_reqs("R5");
      rdy_mode = 1;
      wait_words(40);
      begin
         int bad = 0;
         for (int i = 0; i < 40; i++) begin
            automatic int f = (i < 10) ? 0 : (i < 15) ? 1 : (i < 25) ? 2 : (i < 30) ? 3 : 4;
            automatic int o = (f == 0) ? i : (f == 1) ? i - 10 : (f == 2) ? i - 15 :
                              (f == 3) ? i - 25 : i - 30;
            automatic logic [31:0] b = (f % 2 == 0) ? 32'h1000 : 32'h2000;
            if (got[i] != pat(b + 32'(4 * o))) bad++;
         end
         check(bad == 0, "R5", "words across descriptor changes", bad, 0);
      end

      // R8: zero-length descriptor
      do_reset();
      burst_sel = 2'd1;
      set_desc(0, 32'h110, 32'h3000, 32'h5, 32'hC000_0000);
      set_desc(1, 32'h110, 32'h2000, 32'h6, 32'h0000_0003);
      rdy_mode = 1;
      kick(32'h100);
      wait_words(6);
      repeat (10) @(negedge clk);
      add_exp(32'h100, 4); add_exp(32'h110, 4); add_exp(32'h2000, 3);
      add_exp(32'h110, 4); add_exp(32'h2000, 3);
      cmp_reqs("R8");
      check(nsof == 1 && neof >= 1, "R8", "pulses from zero-length descriptor", neof, 1);
      check(neof == 1, "R7", "no eof for frames without bit 30", neof, 1);

      // R10: underflow flagging
      do_reset();
      ufl_en = 1'b1;
      set_desc(0, 32'h100, 32'h1000, 32'h7, 32'h0000_0004);
      rdy_mode = 1;
      repeat (20) @(negedge clk);
      check(nufl == 0, "R10", "underflow pulses while idle", nufl, 0);
      kick(32'h100);
      wait_words(8);
      check(nufl > 0, "R10", "underflow pulses while starved", nufl, 1);
      do_reset();
      ufl_en = 1'b0;
      rdy_mode = 1;
      kick(32'h100);
      wait_words(8);
      check(nufl == 0, "R10", "underflow pulses with enable low", nufl, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule